// File: doc/BRIEF.md
# 16-bit ALU with Status Flags

This block is the arithmetic and logic datapath of a small 16-bit RISC CPU core. It is purely combinational. Each cycle the sequencer presents a source operand, a destination operand, a 4-bit operation code, a byte/word select and the current carry, zero, negative and overflow flags. In the same cycle the block returns the result, a hint telling the register stage whether to write the result, the new flag values, and a mask that shows which flags the operation owns.

The block covers two groups of operations. The first group takes two operands: copy, binary add and subtract (with and without carry), compare, packed-decimal add, bit test, bit clear, bit set, exclusive-or and and. The second group takes one operand, which is always presented on the destination input: rotate right through carry, arithmetic shift right, byte swap and sign extension. Each operation has its own flag rule. Some operations leave every flag alone. Compare and bit test compute a value only for its flags. Byte mode narrows both the arithmetic and the flag derivation to the low byte.

Top module: `alu16`

## Requirements
- R1: Operation codes on `op_i` are 0 copy, 1 add, 2 add-with-carry, 3 subtract-with-carry, 4 subtract, 5 compare, 6 decimal add, 7 bit test, 8 bit clear, 9 bit set, 10 xor, 11 and, 12 rotate right through carry, 13 arithmetic shift right, 14 byte swap, 15 sign extend. Copy returns the source, asserts `wr_o`, and has an update mask of zero.
- R2: Flag bit positions on `flg_i`, `flg_o` and `flg_upd_o` are 0 carry (C), 1 zero (Z), 2 negative (N), 3 overflow (V). Every flag whose mask bit is 0 leaves the block equal to its value on `flg_i`.
- R3: Add returns dst+src and add-with-carry returns dst+src+C. Both update all four flags. C is the carry out. V is set on signed overflow. N is the result MSB. Z is set when the result is zero.
- R4: Subtract returns dst+~src+1 and subtract-with-carry returns dst+~src+C. C is the carry out, so C=1 means no borrow. V, N and Z follow the rules of R3.
- R5: Compare computes and flags exactly like subtract, but drives `wr_o` low.
- R6: Decimal add treats dst, src and the incoming C as packed BCD digits. Any digit sum above 9 is corrected by +6 and carries into the next digit. C is set when the total exceeds 9999 (word) or 99 (byte). V is cleared. N and Z follow the result.
- R7: And and bit test return dst&src, and xor returns dst^src. All three set N from the MSB, set Z on zero and set C to the inverse of Z. V is cleared for and and bit test. For xor, V is set only when both operands are negative. Bit test drives `wr_o` low.
- R8: Bit clear returns dst&~src and bit set returns dst|src. Both write the result and have a mask of zero.
- R9: Rotate right through carry shifts the operand right by one. The incoming C enters the MSB and the old LSB becomes C. V is cleared, and N and Z follow the result.
- R10: Arithmetic shift right keeps the MSB, shifts the operand right by one and moves the old LSB into C. V is cleared, and N and Z follow the result.
- R11: Byte swap exchanges the two bytes and has a mask of zero. Sign extend copies bit 7 into bits 15..8. It sets N and Z from the result, sets C to not Z and clears V. Both always act on the full word, whatever `byte_i` says.
- R12: With `byte_i`=1, every other operation uses only bits 7..0 of its operands. Bit 7 is the MSB for N, V and C. Z tests the low byte. Bits 15..8 of `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see R1) |
| byte_i | input | 1 | 1 selects byte width, 0 selects word width |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand; sole operand of the single-operand group |
| flg_i | input | 4 | Incoming flags {V,N,Z,C} |
| res_o | output | 16 | Result value |
| wr_o | output | 1 | Result should be written back |
| flg_o | output | 4 | Outgoing flags {V,N,Z,C} |
| flg_upd_o | output | 4 | Per-flag update mask, 1 = flag set by this operation |

## Verification
The immediate assertions inside the block are evaluated on every input change. They check that unmasked flags pass through unchanged, that Z always agrees with the returned result, and that C is the inverse of Z for the logic-style operations. They also check that compare and bit test never request a write, that copy owns no flag, and that byte-mode results have a clear upper byte. Whether the sums, borrows, decimal corrections, rotations and overflow decisions hold the right values can only be shown by the bench's directed scenarios. Those scenarios compare each output against hand-derived values at the carry, borrow, overflow and decimal-wrap boundaries, in both widths.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;

    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int FLAG_W  = 4;

    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_N = 2;
    localparam int FB_V = 3;

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADDC = 4'd2,
        OP_SUBC = 4'd3,
        OP_SUB  = 4'd4,
        OP_CMP  = 4'd5,
        OP_DADD = 4'd6,
        OP_BIT  = 4'd7,
        OP_BIC  = 4'd8,
        OP_BIS  = 4'd9,
        OP_XOR  = 4'd10,
        OP_AND  = 4'd11,
        OP_RRC  = 4'd12,
        OP_RRA  = 4'd13,
        OP_SWPB = 4'd14,
        OP_SXT  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu16_binadd.sv
`timescale 1ns/1ps
module alu16_binadd #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              co_word_o,
    output logic              co_byte_o,
    output logic              ov_word_o,
    output logic              ov_byte_o
);
    localparam int WMSB = DATA_W - 1;
    localparam int BMSB = BYTE_W - 1;

    logic [DATA_W:0] wide_d;
    logic [BYTE_W:0] low_d;

    always_comb begin
        wide_d = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
        low_d  = {1'b0, a_i[BMSB:0]} + {1'b0, b_i[BMSB:0]} + {{BYTE_W{1'b0}}, cin_i};
    end

    assign sum_o     = wide_d[WMSB:0];
    assign co_word_o = wide_d[DATA_W];
    assign co_byte_o = low_d[BYTE_W];
    assign ov_word_o = (a_i[WMSB] == b_i[WMSB]) && (wide_d[WMSB] != a_i[WMSB]);
    assign ov_byte_o = (a_i[BMSB] == b_i[BMSB]) && (low_d[BMSB] != a_i[BMSB]);

endmodule

// File: rtl/alu16_bcd.sv
`timescale 1ns/1ps
module alu16_bcd #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              co_word_o,
    output logic              co_byte_o
);
    localparam int DIG_W   = 4;
    localparam int DIGITS  = DATA_W / DIG_W;
    localparam int BDIGITS = BYTE_W / DIG_W;

    logic [DIGITS:0] cy_d;

    assign cy_d[0] = cin_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [DIG_W:0] raw_d;
        logic [DIG_W:0] fix_d;
        logic           adj_d;

        always_comb begin
            raw_d = {1'b0, a_i[g*DIG_W +: DIG_W]} + {1'b0, b_i[g*DIG_W +: DIG_W]}
                  + {{DIG_W{1'b0}}, cy_d[g]};
            adj_d = (raw_d > 5'd9);
            fix_d = raw_d + 5'd6;
        end

        assign sum_o[g*DIG_W +: DIG_W] = adj_d ? fix_d[DIG_W-1:0] : raw_d[DIG_W-1:0];
        assign cy_d[g+1] = adj_d;
    end

    assign co_word_o = cy_d[DIGITS];
    assign co_byte_o = cy_d[BDIGITS];

endmodule

// File: rtl/alu16_unary.sv
`timescale 1ns/1ps
module alu16_unary #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] opd_i,
    input  logic              cin_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] rrc_o,
    output logic [DATA_W-1:0] rra_o,
    output logic [DATA_W-1:0] swap_o,
    output logic [DATA_W-1:0] sext_o,
    output logic              lsb_o
);
    localparam int WMSB = DATA_W - 1;
    localparam int BMSB = BYTE_W - 1;
    localparam int UP_W = DATA_W - BYTE_W;

    always_comb begin
        rrc_o = '0;
        rra_o = '0;
        if (narrow_i) begin
            rrc_o[BMSB:0] = {cin_i, opd_i[BMSB:1]};
            rra_o[BMSB:0] = {opd_i[BMSB], opd_i[BMSB:1]};
        end else begin
            rrc_o = {cin_i, opd_i[WMSB:1]};
            rra_o = {opd_i[WMSB], opd_i[WMSB:1]};
        end
        swap_o = {opd_i[BMSB:0], opd_i[WMSB:BYTE_W]};
        sext_o = {{UP_W{opd_i[BMSB]}}, opd_i[BMSB:0]};
    end

    assign lsb_o = opd_i[0];

endmodule

// File: rtl/alu16.sv
`timescale 1ns/1ps
module alu16
    import alu16_pkg::*;
(
    input  logic [3:0]  op_i,
    input  logic        byte_i,
    input  logic [15:0] src_i,
    input  logic [15:0] dst_i,
    input  logic [3:0]  flg_i,
    output logic [15:0] res_o,
    output logic        wr_o,
    output logic [3:0]  flg_o,
    output logic [3:0]  flg_upd_o
);
    localparam int WMSB = DATA_W - 1;
    localparam int BMSB = BYTE_W - 1;
    localparam int UP_W = DATA_W - BYTE_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr;
        logic [FLAG_W-1:0] upd;
        alu_flags_t        flg;
    } alu_out_t;

    alu_op_e     op_d;
    alu_flags_t  fin_d;
    logic        narrow_d;
    logic        sub_d;
    logic        acin_d;
    logic [DATA_W-1:0] addb_d;

    logic [DATA_W-1:0] add_sum_d, bcd_sum_d;
    logic add_cw_d, add_cb_d, add_vw_d, add_vb_d;
    logic bcd_cw_d, bcd_cb_d;
    logic [DATA_W-1:0] rrc_d, rra_d, swp_d, sxt_d;
    logic sh_lsb_d;

    alu_out_t out_d;

    always_comb begin
        op_d     = alu_op_e'(op_i);
        fin_d    = alu_flags_t'(flg_i);
        narrow_d = byte_i && (op_d != OP_SWPB) && (op_d != OP_SXT);
        sub_d    = (op_d == OP_SUB) || (op_d == OP_SUBC) || (op_d == OP_CMP);
        addb_d   = sub_d ? ~src_i : src_i;
        unique case (op_d)
            OP_ADDC, OP_SUBC: acin_d = fin_d.c;
            OP_SUB,  OP_CMP:  acin_d = 1'b1;
            default:          acin_d = 1'b0;
        endcase
    end

    alu16_binadd #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_add (
        .a_i       (dst_i),
        .b_i       (addb_d),
        .cin_i     (acin_d),
        .sum_o     (add_sum_d),
        .co_word_o (add_cw_d),
        .co_byte_o (add_cb_d),
        .ov_word_o (add_vw_d),
        .ov_byte_o (add_vb_d)
    );

    alu16_bcd #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bcd (
        .a_i       (dst_i),
        .b_i       (src_i),
        .cin_i     (fin_d.c),
        .sum_o     (bcd_sum_d),
        .co_word_o (bcd_cw_d),
        .co_byte_o (bcd_cb_d)
    );

    alu16_unary #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_una (
        .opd_i    (dst_i),
        .cin_i    (fin_d.c),
        .narrow_i (narrow_d),
        .rrc_o    (rrc_d),
        .rra_o    (rra_d),
        .swap_o   (swp_d),
        .sext_o   (sxt_d),
        .lsb_o    (sh_lsb_d)
    );

    always_comb begin
        logic [DATA_W-1:0] raw;
        logic [DATA_W-1:0] res;
        logic              msb_n;
        logic              zero;
        alu_flags_t        nf;

        raw       = '0;
        out_d.wr  = 1'b1;
        out_d.upd = {FLAG_W{1'b1}};

        unique case (op_d)
            OP_MOV:                                raw = src_i;
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC:      raw = add_sum_d;
            OP_CMP: begin
                raw      = add_sum_d;
                out_d.wr = 1'b0;
            end
            OP_DADD:                               raw = bcd_sum_d;
            OP_BIT: begin
                raw      = dst_i & src_i;
                out_d.wr = 1'b0;
            end
            OP_AND:                                raw = dst_i & src_i;
            OP_XOR:                                raw = dst_i ^ src_i;
            OP_BIC:                                raw = dst_i & ~src_i;
            OP_BIS:                                raw = dst_i | src_i;
            OP_RRC:                                raw = rrc_d;
            OP_RRA:                                raw = rra_d;
            OP_SWPB:                               raw = swp_d;
            OP_SXT:                                raw = sxt_d;
            default:                               raw = src_i;
        endcase

        if (op_d inside {OP_MOV, OP_BIC, OP_BIS, OP_SWPB}) begin
            out_d.upd = '0;
        end

        res   = narrow_d ? {{UP_W{1'b0}}, raw[BMSB:0]} : raw;
        msb_n = narrow_d ? res[BMSB] : res[WMSB];
        zero  = (res == '0);

        nf.n = msb_n;
        nf.z = zero;
        nf.c = ~zero;
        nf.v = 1'b0;

        unique case (op_d)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                nf.c = narrow_d ? add_cb_d : add_cw_d;
                nf.v = narrow_d ? add_vb_d : add_vw_d;
            end
            OP_DADD: begin
                nf.c = narrow_d ? bcd_cb_d : bcd_cw_d;
            end
            OP_XOR: begin
                nf.v = narrow_d ? (src_i[BMSB] & dst_i[BMSB])
                                : (src_i[WMSB] & dst_i[WMSB]);
            end
            OP_RRC, OP_RRA: begin
                nf.c = sh_lsb_d;
            end
            default: ;
        endcase

        out_d.res = res;
        out_d.flg = alu_flags_t'((flg_i & ~out_d.upd) | (nf & out_d.upd));
    end

    assign res_o     = out_d.res;
    assign wr_o      = out_d.wr;
    assign flg_o     = out_d.flg;
    assign flg_upd_o = out_d.upd;

    always_comb begin
        AST_HOLD_UNOWNED: assert ((flg_o & ~flg_upd_o) == (flg_i & ~flg_upd_o)); // R2
        AST_COPY_NO_FLAGS: assert (op_i != 4'd0 || (flg_upd_o == 4'd0 && wr_o)); // R1
        AST_CMP_NO_WRITE: assert (op_i != 4'd5 || !wr_o); // R5
        AST_BIT_NO_WRITE: assert (op_i != 4'd7 || !wr_o); // R7
        AST_Z_FROM_RESULT: assert (!flg_upd_o[FB_Z] || (flg_o[FB_Z] == (res_o == 16'd0))); // R3
        AST_LOGIC_C_NOT_Z: assert (!(op_i inside {4'd7, 4'd10, 4'd11, 4'd15})
                                   || (flg_o[FB_C] == ~flg_o[FB_Z])); // R7
        AST_BYTE_UPPER_CLEAR: assert (!byte_i || op_i == 4'd14 || op_i == 4'd15
                                      || res_o[15:8] == 8'd0); // R12
    end

endmodule

// File: tb/tb_alu16.sv
`timescale 1ns/1ps
module tb_alu16;

    logic        clk = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic        byte_i = 1'b0;
    logic [15:0] src_i = 16'd0;
    logic [15:0] dst_i = 16'd0;
    logic [3:0]  flg_i = 4'd0;
    logic [15:0] res_o;
    logic        wr_o;
    logic [3:0]  flg_o;
    logic [3:0]  flg_upd_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    alu16 dut (
        .op_i      (op_i),
        .byte_i    (byte_i),
        .src_i     (src_i),
        .dst_i     (dst_i),
        .flg_i     (flg_i),
        .res_o     (res_o),
        .wr_o      (wr_o),
        .flg_o     (flg_o),
        .flg_upd_o (flg_upd_o)
    );

    // flags written as {V,N,Z,C}
    task automatic run(input string tag, input logic [3:0] op, input logic bw,
                       input logic [15:0] s, input logic [15:0] d, input logic [3:0] fi,
                       input logic [15:0] eres, input logic ewr,
                       input logic [3:0] eupd, input logic [3:0] eflg);
        @(negedge clk);
        op_i = op; byte_i = bw; src_i = s; dst_i = d; flg_i = fi;
        #1;
        total++;
        if (res_o !== eres || wr_o !== ewr || flg_upd_o !== eupd || flg_o !== eflg) begin
            bad++;
            $display("FAIL %s: res=%h wr=%b upd=%b flg=%b expected res=%h wr=%b upd=%b flg=%b",
                     tag, res_o, wr_o, flg_upd_o, flg_o, eres, ewr, eupd, eflg);
        end
    endtask

    task automatic t_reset_idle;
        // all-zero inputs select copy of zero: flags pass through
        run("R1 idle", 4'd0, 1'b0, 16'h0000, 16'h0000, 4'b0000, 16'h0000, 1'b1, 4'b0000, 4'b0000);
    endtask

    task automatic t_copy;
        run("R1 copy", 4'd0, 1'b0, 16'h1234, 16'hFFFF, 4'b1010, 16'h1234, 1'b1, 4'b0000, 4'b1010);
        run("R2 copy hold", 4'd0, 1'b0, 16'h0000, 16'h5555, 4'b0101, 16'h0000, 1'b1, 4'b0000, 4'b0101);
        run("R12 copy byte", 4'd0, 1'b1, 16'h12AB, 16'h0000, 4'b0000, 16'h00AB, 1'b1, 4'b0000, 4'b0000);
    endtask

    task automatic t_add;
        run("R3 add ovf", 4'd1, 1'b0, 16'h0001, 16'h7FFF, 4'b0000, 16'h8000, 1'b1, 4'b1111, 4'b1100);
        run("R3 add wrap", 4'd1, 1'b0, 16'h0001, 16'hFFFF, 4'b0000, 16'h0000, 1'b1, 4'b1111, 4'b0011);
        run("R3 addc", 4'd2, 1'b0, 16'h0001, 16'h0001, 4'b0001, 16'h0003, 1'b1, 4'b1111, 4'b0000);
    endtask

    task automatic t_sub;
        run("R4 sub", 4'd4, 1'b0, 16'h0003, 16'h0005, 4'b0000, 16'h0002, 1'b1, 4'b1111, 4'b0001);
        run("R4 sub borrow", 4'd4, 1'b0, 16'h0005, 16'h0003, 4'b0000, 16'hFFFE, 1'b1, 4'b1111, 4'b0100);
        run("R4 subc", 4'd3, 1'b0, 16'h0003, 16'h0005, 4'b0000, 16'h0001, 1'b1, 4'b1111, 4'b0001);
        run("R4 sub ovf", 4'd4, 1'b0, 16'h0001, 16'h8000, 4'b0000, 16'h7FFF, 1'b1, 4'b1111, 4'b1001);
    endtask

    task automatic t_cmp;
        run("R5 cmp equal", 4'd5, 1'b0, 16'h0005, 16'h0005, 4'b0000, 16'h0000, 1'b0, 4'b1111, 4'b0011);
    endtask

    task automatic t_dadd;
        run("R6 dadd", 4'd6, 1'b0, 16'h0199, 16'h1234, 4'b0000, 16'h1433, 1'b1, 4'b1111, 4'b0000);
        run("R6 dadd wrap", 4'd6, 1'b0, 16'h0001, 16'h9999, 4'b0000, 16'h0000, 1'b1, 4'b1111, 4'b0011);
        run("R6 dadd cin", 4'd6, 1'b0, 16'h0051, 16'h0048, 4'b0001, 16'h0100, 1'b1, 4'b1111, 4'b0000);
        run("R6 dadd byte", 4'd6, 1'b1, 16'h3301, 16'h5599, 4'b1000, 16'h0000, 1'b1, 4'b1111, 4'b0011);
    endtask

    task automatic t_logic;
        run("R7 and", 4'd11, 1'b0, 16'h0FF0, 16'hF0F0, 4'b1000, 16'h00F0, 1'b1, 4'b1111, 4'b0001);
        run("R7 bit", 4'd7, 1'b0, 16'h8001, 16'h8000, 4'b0000, 16'h8000, 1'b0, 4'b1111, 4'b0101);
        run("R7 bit zero", 4'd7, 1'b0, 16'hFF00, 16'h00FF, 4'b0001, 16'h0000, 1'b0, 4'b1111, 4'b0010);
        run("R7 xor", 4'd10, 1'b0, 16'h8000, 16'h8001, 4'b0000, 16'h0001, 1'b1, 4'b1111, 4'b1001);
    endtask

    task automatic t_bic_bis;
        run("R8 bic", 4'd8, 1'b0, 16'h00F0, 16'hFFFF, 4'b0110, 16'hFF0F, 1'b1, 4'b0000, 4'b0110);
        run("R8 bis", 4'd9, 1'b0, 16'h00F0, 16'h0F00, 4'b1001, 16'h0FF0, 1'b1, 4'b0000, 4'b1001);
    endtask

    task automatic t_shift;
        run("R9 rrc in", 4'd12, 1'b0, 16'h0000, 16'h0001, 4'b0001, 16'h8000, 1'b1, 4'b1111, 4'b0101);
        run("R9 rrc", 4'd12, 1'b0, 16'h0000, 16'h0002, 4'b1000, 16'h0001, 1'b1, 4'b1111, 4'b0000);
        run("R9 rrc byte", 4'd12, 1'b1, 16'h0000, 16'h1201, 4'b0001, 16'h0080, 1'b1, 4'b1111, 4'b0101);
        run("R10 rra", 4'd13, 1'b0, 16'h0000, 16'h8003, 4'b0000, 16'hC001, 1'b1, 4'b1111, 4'b0101);
        run("R10 rra byte", 4'd13, 1'b1, 16'h0000, 16'h0081, 4'b0000, 16'h00C0, 1'b1, 4'b1111, 4'b0101);
    endtask

    task automatic t_swap_sext;
        run("R11 swpb", 4'd14, 1'b0, 16'h0000, 16'h12AB, 4'b1111, 16'hAB12, 1'b1, 4'b0000, 4'b1111);
        run("R11 swpb byte", 4'd14, 1'b1, 16'h0000, 16'h12AB, 4'b0000, 16'hAB12, 1'b1, 4'b0000, 4'b0000);
        run("R11 sxt neg", 4'd15, 1'b0, 16'h0000, 16'h0080, 4'b1000, 16'hFF80, 1'b1, 4'b1111, 4'b0101);
        run("R11 sxt zero", 4'd15, 1'b1, 16'h0000, 16'hFF00, 4'b0000, 16'h0000, 1'b1, 4'b1111, 4'b0010);
    endtask

    task automatic t_byte_arith;
        run("R12 add byte ovf", 4'd1, 1'b1, 16'h0001, 16'h007F, 4'b0000, 16'h0080, 1'b1, 4'b1111, 4'b1100);
        run("R12 add byte carry", 4'd1, 1'b1, 16'h3401, 16'h12FF, 4'b0000, 16'h0000, 1'b1, 4'b1111, 4'b0011);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset_idle();
        t_copy();
        t_add();
        t_sub();
        t_cmp();
        t_dadd();
        t_logic();
        t_bic_bis();
        t_shift();
        t_swap_sext();
        t_byte_arith();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule